// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Protocol Engine

This block is the slave side of a two-wire serial bus that sits in front of a 256-byte memory. It oversamples the clock line and the data line with a fast system clock, finds start, repeated-start and stop conditions, and shifts bytes most significant bit first. It acknowledges a device select byte whose upper nibble is the fixed type code 1011 and whose next three bits match the chip-enable pins. It then runs one of three kinds of transfer: a write, a random read or a current-address read.

In a write, the first byte after device select loads the address counter. Each data byte that follows leaves the block as an item on a valid/ready stream to an external write sequencer. The address travels with the data and then advances. In a read, the block fetches bytes through a combinational memory read port addressed by the counter. It drives them out on an open-drain output enable and advances the counter after each byte, so reads continue in sequence and wrap from 255 to 0.

Back-pressure rules for the write stream: `wr_valid` stays high, with address and data held, until `wr_ready` is high on a clock edge. The serial bus cannot be stalled. A data byte that completes while an earlier item is still pending is therefore refused with a NoAck and dropped. A write-lock input refuses every data byte while it is high, but device select and address bytes are still acknowledged. The system clock must run at least 8 times faster than the serial clock.

Top module: `tw_mem_slave`

## Requirements
- R1: After reset, `sda_oe` is 0, `wr_valid` is 0 and `mem_raddr` is 0.
- R2: A first byte after start equal to {1011, chip_sel[2:0], rw} (bit 7 first) is acknowledged by holding `sda_oe` high during the ninth clock. rw = 1 selects a read and rw = 0 selects a write.
- R3: A first byte whose bits 7..4 differ from 1011, or whose bits 3..1 differ from `chip_sel`, is not acknowledged. Later bytes get no acknowledge and produce no write until the next start.
- R4: In a write, the byte after device select loads the address counter and is acknowledged. Every accepted data byte is acknowledged and appears once on the write stream with the current address, and the address then advances by one.
- R5: While `wr_lock` is 1, device select and address bytes are still acknowledged, but data bytes get a NoAck and produce no write item.
- R6: A pending write item keeps `wr_valid`, `wr_addr` and `wr_data` unchanged until `wr_ready` is 1. A data byte that completes while an item is pending gets a NoAck and is dropped.
- R7: A random read (write select, address byte, repeated start, read select) returns the memory byte at that address, most significant bit first.
- R8: A current-address read returns the byte at the address that follows the last byte transferred.
- R9: While the master acknowledges, a read continues with consecutive addresses, and the address wraps from 255 to 0.
- R10: After a master NoAck, the block releases SDA and leaves it released for further clocks until the next start.
- R11: A start seen in the middle of a byte drops that transfer and begins device select reception again.
- R12: After a stop, bytes clocked without a new start are not acknowledged.
- R13: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| chip_sel | input | 3 | Chip-enable pattern matched against select bits 3..1 |
| wr_lock | input | 1 | 1 refuses all data bytes of writes |
| mem_raddr | output | 8 | Read address, equal to the address counter |
| mem_rdata | input | 8 | Memory byte at `mem_raddr` (combinational) |
| wr_valid | output | 1 | A write item is offered |
| wr_ready | input | 1 | Write sequencer takes the item |
| wr_addr | output | 8 | Address of the offered write item |
| wr_data | output | 8 | Data of the offered write item |

## Verification
The hardest case to reach from the ports is a data byte that completes while an earlier write item is still unaccepted. To reach it, the bench holds `wr_ready` low across two data bytes of one write, checks that the first item stays frozen and the second gets a NoAck, and then releases ready so the scoreboard sees exactly one item. A start in the middle of a byte is also reached on purpose: the bench clocks four bits, issues a start, and checks that a read select which follows is acknowledged.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVSEL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } tw_state_e;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic q_prev
);
  logic [STAGES:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES + 1; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= INIT;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign q      = chain[STAGES-1];
  assign q_prev = chain[STAGES];
endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events (
  input  logic scl,
  input  logic scl_prev,
  input  logic sda,
  input  logic sda_prev,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);
  always_comb begin
    start_ev = scl && scl_prev && sda_prev && !sda;
    stop_ev  = scl && scl_prev && !sda_prev && sda;
    scl_rise = scl && !scl_prev;
    scl_fall = !scl && scl_prev;
  end
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
  import tw_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [3:0]  DEV_TYPE    = 4'b1011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        chip_sel,
  input  logic              wr_lock,
  output logic [BYTE_W-1:0] mem_raddr,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

  logic scl_s, scl_p, sda_s, sda_p;
  logic start_ev, stop_ev, scl_rise, scl_fall;

  tw_line_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s), .q_prev(scl_p));
  tw_line_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s), .q_prev(sda_p));

  tw_bus_events u_events (
    .scl(scl_s), .scl_prev(scl_p), .sda(sda_s), .sda_prev(sda_p),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall));

  tw_state_e         state, nxt;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg, addr;
  logic              mack, oe_r, dev_hit;

  assign dev_hit   = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == chip_sel);
  assign sda_oe    = oe_r;
  assign mem_raddr = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      nxt      <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      addr     <= '0;
      mack     <= 1'b0;
      oe_r     <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      if (wr_valid && wr_ready) wr_valid <= 1'b0;

      if (start_ev) begin
        state   <= ST_DEVSEL;
        bit_cnt <= '0;
        oe_r    <= 1'b0;
      end else if (stop_ev) begin
        state   <= ST_IDLE;
        bit_cnt <= '0;
        oe_r    <= 1'b0;
      end else begin
        case (state)
          ST_RDATA: begin
            if (scl_rise) begin
              if (bit_cnt < LAST_BIT) bit_cnt <= bit_cnt + 1'b1;
              else if (bit_cnt == ACK_BIT) mack <= !sda_s;
            end
            if (scl_fall) begin
              if (bit_cnt != '0 && bit_cnt < LAST_BIT) begin
                shreg <= {shreg[BYTE_W-2:0], 1'b0};
                oe_r  <= !shreg[BYTE_W-2];
              end else if (bit_cnt == LAST_BIT) begin
                oe_r    <= 1'b0;
                addr    <= addr + 1'b1;
                bit_cnt <= ACK_BIT;
              end else if (bit_cnt == ACK_BIT) begin
                bit_cnt <= '0;
                if (mack) begin
                  shreg <= mem_rdata;
                  oe_r  <= !mem_rdata[BYTE_W-1];
                end else begin
                  state <= ST_IDLE;
                end
              end
            end
          end
          ST_DEVSEL, ST_ADDR, ST_WDATA: begin
            if (scl_rise && bit_cnt < LAST_BIT) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end
            if (scl_fall && bit_cnt == LAST_BIT) begin
              bit_cnt <= ACK_BIT;
              case (state)
                ST_DEVSEL: begin
                  if (dev_hit) begin
                    oe_r <= 1'b1;
                    nxt  <= shreg[0] ? ST_RDATA : ST_ADDR;
                  end else begin
                    state   <= ST_IDLE;
                    bit_cnt <= '0;
                  end
                end
                ST_ADDR: begin
                  oe_r <= 1'b1;
                  addr <= shreg;
                  nxt  <= ST_WDATA;
                end
                default: begin
                  nxt <= ST_WDATA;
                  if (!wr_lock && !wr_valid) begin
                    oe_r     <= 1'b1;
                    wr_valid <= 1'b1;
                    wr_addr  <= addr;
                    wr_data  <= shreg;
                    addr     <= addr + 1'b1;
                  end
                end
              endcase
            end else if (scl_fall && bit_cnt == ACK_BIT) begin
              oe_r    <= 1'b0;
              bit_cnt <= '0;
              state   <= nxt;
              if (nxt == ST_RDATA) begin
                shreg <= mem_rdata;
                oe_r  <= !mem_rdata[BYTE_W-1];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tw_mem_slave_chk.sv
module tw_mem_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       wr_lock,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] mem_raddr
);
  // R13
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R6
  hold_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)));

  // R5
  lock_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> !$past(wr_lock));

  // R4
  item_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> (wr_addr == $past(mem_raddr)));
endmodule

bind tw_mem_slave tw_mem_slave_chk u_chk (.*);

// File: tb/sim_tw_mem_slave.sv
module sim_tw_mem_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_valid, wr_ready = 1'b1, wr_lock = 1'b0;
  logic [2:0] chip_sel = 3'b101;
  logic [7:0] mem_raddr, mem_rdata, wr_addr, wr_data;
  logic sda_line;
  logic [7:0] mem [256];
  logic [15:0] exp_q [$];
  int checks = 0, fails = 0, r13_bad = 0;
  logic oe_prev = 1'b0;

  always #4 clk = ~clk;
  assign sda_line  = sda_m & ~sda_oe;
  assign mem_rdata = mem[mem_raddr];

  tw_mem_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .chip_sel(chip_sel), .wr_lock(wr_lock), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data));

  function automatic logic [7:0] init_val(input logic [7:0] a);
    return a ^ 8'hA5;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor for the write stream (R4, R6)
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R4 unexpected write item", {wr_addr, wr_data}, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check({wr_addr, wr_data} == e, "R4 write item", {wr_addr, wr_data}, e);
      end
      mem[wr_addr] = wr_data;
    end
    if (rst_n && (sda_oe != oe_prev) && scl_m) r13_bad++;
    oe_prev = sda_oe;
  end

  task automatic wq; repeat (8) @(negedge clk); endtask

  task automatic bus_start;
    sda_m = 1'b1; wq; scl_m = 1'b1; wq; sda_m = 1'b0; wq; scl_m = 1'b0; wq;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq; scl_m = 1'b1; wq; sda_m = 1'b1; wq; wq;
  endtask

  task automatic bus_bit(input logic b, output logic r);
    sda_m = b; wq; scl_m = 1'b1; wq; r = sda_line; wq; scl_m = 1'b0; wq;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(d[i], r);
    bus_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic r;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      bus_bit(1'b1, r);
      d = {d[6:0], r};
    end
    bus_bit(!give_ack, r);
  endtask

  task automatic push_exp(input logic [7:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) mem[i] = init_val(8'(i));
    repeat (4) @(negedge clk);
    check(sda_oe == 0 && wr_valid == 0 && mem_raddr == 0, "R1 reset state",
          {sda_oe, wr_valid, mem_raddr}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 / R4: write two bytes at 0x10
    bus_start;
    send_byte(8'hBA, ack); check(ack, "R2 write select ack", ack, 1);
    send_byte(8'h10, ack); check(ack, "R4 address ack", ack, 1);
    push_exp(8'h10, 8'h11);
    send_byte(8'h11, ack); check(ack, "R4 data ack 1", ack, 1);
    push_exp(8'h11, 8'h22);
    send_byte(8'h22, ack); check(ack, "R4 data ack 2", ack, 1);
    bus_stop;

    // R7 random read then R9 sequential
    bus_start;
    send_byte(8'hBA, ack);
    send_byte(8'h10, ack);
    bus_start;
    send_byte(8'hBB, ack); check(ack, "R2 read select ack", ack, 1);
    recv_byte(1'b1, d); check(d == 8'h11, "R7 random read", d, 8'h11);
    recv_byte(1'b1, d); check(d == 8'h22, "R9 sequential read", d, 8'h22);
    recv_byte(1'b0, d); check(d == init_val(8'h12), "R9 sequential read 3", d, init_val(8'h12));
    bus_stop;

    // R8 current address read
    bus_start;
    send_byte(8'hBB, ack);
    recv_byte(1'b0, d); check(d == init_val(8'h13), "R8 current address", d, init_val(8'h13));
    bus_stop;

    // R9 wrap 255 -> 0
    bus_start;
    send_byte(8'hBA, ack);
    send_byte(8'hFE, ack);
    bus_start;
    send_byte(8'hBB, ack);
    recv_byte(1'b1, d); check(d == init_val(8'hFE), "R9 read FE", d, init_val(8'hFE));
    recv_byte(1'b1, d); check(d == init_val(8'hFF), "R9 read FF", d, init_val(8'hFF));
    recv_byte(1'b0, d); check(d == init_val(8'h00), "R9 wrap to 00", d, init_val(8'h00));
    bus_stop;

    // R3 mismatches
    bus_start;
    send_byte(8'hB2, ack); check(!ack, "R3 chip mismatch nack", ack, 0);
    send_byte(8'h55, ack); check(!ack, "R3 later byte nack", ack, 0);
    bus_stop;
    bus_start;
    send_byte(8'hAA, ack); check(!ack, "R3 type mismatch nack", ack, 0);
    bus_stop;

    // R10 release after master NoAck (current address now 0x01)
    bus_start;
    send_byte(8'hBB, ack);
    recv_byte(1'b0, d); check(d == init_val(8'h01), "R10 read before noack", d, init_val(8'h01));
    recv_byte(1'b0, d); check(d == 8'hFF, "R10 bus released", d, 8'hFF);
    bus_stop;

    // R5 write lock
    wr_lock = 1'b1;
    bus_start;
    send_byte(8'hBA, ack); check(ack, "R5 select ack under lock", ack, 1);
    send_byte(8'h40, ack); check(ack, "R5 address ack under lock", ack, 1);
    send_byte(8'h77, ack); check(!ack, "R5 data nack under lock", ack, 0);
    send_byte(8'h78, ack); check(!ack, "R5 data nack under lock 2", ack, 0);
    bus_stop;
    wr_lock = 1'b0;
    bus_start;
    send_byte(8'hBA, ack);
    send_byte(8'h40, ack);
    bus_start;
    send_byte(8'hBB, ack);
    recv_byte(1'b0, d); check(d == init_val(8'h40), "R5 memory untouched", d, init_val(8'h40));
    bus_stop;

    // R6 back-pressure
    wr_ready = 1'b0;
    bus_start;
    send_byte(8'hBA, ack);
    send_byte(8'h50, ack);
    push_exp(8'h50, 8'h99);
    send_byte(8'h99, ack); check(ack, "R6 first byte ack", ack, 1);
    send_byte(8'h9A, ack); check(!ack, "R6 second byte nack while pending", ack, 0);
    check(wr_valid && wr_data == 8'h99 && wr_addr == 8'h50, "R6 item held",
          {wr_valid, wr_addr, wr_data}, {1'b1, 8'h50, 8'h99});
    wr_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(!wr_valid, "R6 item taken", wr_valid, 0);
    bus_stop;

    // R11 start in the middle of a byte (address now 0x51)
    bus_start;
    send_byte(8'hBA, ack);
    begin
      logic r;
      bus_bit(1'b1, r); bus_bit(1'b0, r); bus_bit(1'b1, r); bus_bit(1'b1, r);
    end
    bus_start;
    send_byte(8'hBB, ack); check(ack, "R11 select after abort", ack, 1);
    recv_byte(1'b0, d); check(d == init_val(8'h51), "R11 read after abort", d, init_val(8'h51));
    bus_stop;

    // R12 no response after stop without start
    scl_m = 1'b0; wq;
    send_byte(8'hBA, ack); check(!ack, "R12 no ack without start", ack, 0);
    scl_m = 1'b1; wq; wq;

    check(exp_q.size() == 0, "R4 all expected items seen", exp_q.size(), 0);
    check(r13_bad == 0, "R13 drive changes only with SCL low", r13_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule